// File: doc/BRIEF.md
# UART Idle Line Detector

This block sits beside a UART receiver and reports when the receive line has gone quiet. It takes the already-synchronized line level, the receiver's per-bit sampling strobe and a few framing events. It counts consecutive high bit times and raises a sticky flag once that count covers one full character time. A character time is configured between 10 and 13 bit times.

The count can start at one of two points, chosen by a mode input. In the first mode it starts right after the start bit, so the high data bits at the tail of a character and its stop bits already count toward the idle time. In the second mode it starts only at the end of the stop bits, so nothing inside the character counts.

The flag is one-shot. Setting it disarms the detector. Only a newly stored character or a break event re-arms it, so a long silence produces a single flag no matter how long it lasts. Software clears the flag with a write-one strobe.

Top module: `uart_idle_detect`

## Requirements
- R1: After reset the flag is 0 and the detector is disarmed; high bit times, even after a start event, never set the flag until a character is stored or a break occurs.
- R2: The character time is `char_len` bit times, with values below 10 treated as 10 and values above 13 treated as 13.
- R3: With `idle_after_stop` = 0, a start event zeroes the count and counting runs from then on. The trailing high data bits and the stop bit each add one bit time, so a character whose last k data bits are high needs `len - k - 1` further idle ticks.
- R4: With `idle_after_stop` = 1, the count is held at zero from a start event until the stop-end event, so exactly `len` idle ticks are needed after the stop bits.
- R5: A bit tick that samples the line low zeroes the count.
- R6: The count saturates at the character time, and the flag sets only once per arming, however long the line stays high.
- R7: A `clear_w1c` pulse clears the flag, unless a set occurs in the same cycle, in which case the set wins.
- R8: A `char_stored` or `break_set` pulse arms the detector. An armed detector whose count has reached the character time sets the flag one clock later.
- R9: Once set, the flag holds until cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_level | input | 1 | Synchronized receive line level |
| bit_tick | input | 1 | One-cycle strobe at each bit sampling point |
| start_evt | input | 1 | One-cycle strobe when a start bit is detected |
| stop_end_evt | input | 1 | One-cycle strobe at the end of the stop bits |
| char_stored | input | 1 | One-cycle strobe when a character enters the receive buffer |
| break_set | input | 1 | One-cycle strobe when the break flag is set |
| char_len | input | 4 | Character time in bit times (clamped to 10..13) |
| idle_after_stop | input | 1 | 0: count from start bit; 1: count from end of stop bits |
| clear_w1c | input | 1 | Write-one-to-clear strobe for the flag |
| idle_flag | output | 1 | Sticky idle-line flag |

## Verification
The bench uses the default parameters: a 4-bit length field with bounds 10 and 13. Those bounds let it reach both clamp directions with lengths 9 and 15. Each table vector sends one 8-bit frame in a chosen mode and length, then counts idle ticks until the flag appears. The data patterns (all ones, all zeros, high nibble, interleaved) move the point where the count starts in the start-bit mode. Directed tests cover disarm after reset, the one-shot behaviour, re-arming by break, a low glitch during idle, and stickiness.

// File: rtl/uart_idle_pkg.sv
// Package: shared types for the UART idle line detector.
// Assumes: nothing beyond standard SystemVerilog.
package uart_idle_pkg;

    // Where idle counting begins within a character.
    typedef enum logic {
        IDLE_FROM_START = 1'b0,
        IDLE_FROM_STOP  = 1'b1
    } idle_mode_e;

endpackage

// File: rtl/idle_len_limit.sv
// Module: idle_len_limit
// Turns the configured character length into the idle threshold,
// clamping it into [MIN_BITS, MAX_BITS].
// Assumes: char_len is quasi-static while a character is being counted.
module idle_len_limit #(
    parameter int LEN_W    = 4,
    parameter int MIN_BITS = 10,
    parameter int MAX_BITS = 13,
    parameter int CNT_W    = $clog2(MAX_BITS + 1)
) (
    input  logic [LEN_W-1:0] char_len,
    output logic [CNT_W-1:0] limit
);

    // Clamp the requested length into the legal window.
    always_comb begin
        if (int'(char_len) < MIN_BITS) begin
            limit = CNT_W'(MIN_BITS);
        end else if (int'(char_len) > MAX_BITS) begin
            limit = CNT_W'(MAX_BITS);
        end else begin
            limit = CNT_W'(char_len);
        end
    end

endmodule

// File: rtl/idle_bit_counter.sv
// Module: idle_bit_counter
// Counts consecutive high bit times once counting is enabled. The enable
// opens at the start event (mode FROM_START) or at the stop-end event
// (mode FROM_STOP). The count saturates at limit.
// Assumes: event strobes are single-cycle; a start event takes priority
// over a stop-end event, which takes priority over a bit tick.
module idle_bit_counter
    import uart_idle_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_level,
    input  logic             bit_tick,
    input  logic             start_evt,
    input  logic             stop_end_evt,
    input  idle_mode_e       idle_mode,
    input  logic [CNT_W-1:0] limit,
    output logic [CNT_W-1:0] cnt,
    output logic             reached
);

    logic gate;

    // Counter and counting window update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt  <= '0;
            gate <= 1'b0;
        end else if (start_evt) begin
            cnt  <= '0;
            gate <= (idle_mode == IDLE_FROM_START);
        end else if (stop_end_evt && (idle_mode == IDLE_FROM_STOP)) begin
            cnt  <= '0;
            gate <= 1'b1;
        end else if (bit_tick) begin
            if (!rx_level) begin
                cnt <= '0;
            end else if (gate && (cnt < limit)) begin
                cnt <= cnt + 1'b1;
            end
        end
    end

    // Threshold compare: a full character time of high level seen.
    always_comb reached = gate && (cnt >= limit);

    // R5
    low_zeroes_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bit_tick && !rx_level && !start_evt && !stop_end_evt) |=> (cnt == '0));

    // R3
    start_zeroes_cnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_evt |=> (cnt == '0));

    // R4
    stop_mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && idle_mode == IDLE_FROM_STOP) |=> !reached);

    // R6
    cnt_saturate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == limit && !start_evt && !stop_end_evt && bit_tick && rx_level)
        |=> (cnt == $past(cnt)));

endmodule

// File: rtl/idle_flag_ctrl.sv
// Module: idle_flag_ctrl
// Holds the arm state and the sticky flag. Setting the flag disarms the
// detector; a stored character or a break re-arms it.
// Assumes: reached comes from idle_bit_counter; strobes are single-cycle.
module idle_flag_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic reached,
    input  logic char_stored,
    input  logic break_set,
    input  logic clear_w1c,
    output logic armed,
    output logic idle_flag
);

    logic set_now;
    logic rearm;

    // Set and re-arm conditions.
    always_comb begin
        set_now = armed && reached;
        rearm   = char_stored || break_set;
    end

    // Arm state: re-arm has priority over the disarm that a set causes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (rearm) begin
            armed <= 1'b1;
        end else if (set_now) begin
            armed <= 1'b0;
        end
    end

    // Sticky flag: set wins over a simultaneous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            idle_flag <= 1'b0;
        end else if (set_now) begin
            idle_flag <= 1'b1;
        end else if (clear_w1c) begin
            idle_flag <= 1'b0;
        end
    end

    // R8
    set_needs_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(idle_flag) |-> $past(armed));

    // R6
    set_disarms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed && reached && !char_stored && !break_set) |=> !armed);

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_flag && !clear_w1c) |=> idle_flag);

    // R7
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clear_w1c && !(armed && reached)) |=> !idle_flag);

endmodule

// File: rtl/uart_idle_detect.sv
// Module: uart_idle_detect (top)
// Raises a sticky one-shot flag once the receive line has stayed high for
// one full character time after activity.
// Assumes: rx_level is synchronized; strobes come from the receiver's
// bit timing and framing logic in the same clock domain.
module uart_idle_detect
    import uart_idle_pkg::*;
#(
    parameter int LEN_W    = 4,
    parameter int MIN_BITS = 10,
    parameter int MAX_BITS = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_level,
    input  logic             bit_tick,
    input  logic             start_evt,
    input  logic             stop_end_evt,
    input  logic             char_stored,
    input  logic             break_set,
    input  logic [LEN_W-1:0] char_len,
    input  logic             idle_after_stop,
    input  logic             clear_w1c,
    output logic             idle_flag
);

    localparam int CNT_W = $clog2(MAX_BITS + 1);

    logic [CNT_W-1:0] limit;
    logic [CNT_W-1:0] cnt;
    logic             reached;
    logic             armed;
    idle_mode_e       idle_mode;

    // Map the plain mode pin onto the enum.
    always_comb idle_mode = idle_mode_e'(idle_after_stop);

    idle_len_limit #(
        .LEN_W    (LEN_W),
        .MIN_BITS (MIN_BITS),
        .MAX_BITS (MAX_BITS),
        .CNT_W    (CNT_W)
    ) u_limit (
        .char_len (char_len),
        .limit    (limit)
    );

    idle_bit_counter #(
        .CNT_W (CNT_W)
    ) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .rx_level     (rx_level),
        .bit_tick     (bit_tick),
        .start_evt    (start_evt),
        .stop_end_evt (stop_end_evt),
        .idle_mode    (idle_mode),
        .limit        (limit),
        .cnt          (cnt),
        .reached      (reached)
    );

    idle_flag_ctrl u_flag (
        .clk         (clk),
        .rst_n       (rst_n),
        .reached     (reached),
        .char_stored (char_stored),
        .break_set   (break_set),
        .clear_w1c   (clear_w1c),
        .armed       (armed),
        .idle_flag   (idle_flag)
    );

    // R2
    limit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(limit) >= MIN_BITS) && (int'(limit) <= MAX_BITS));

    // R1
    reset_flag_chk: assert property (@(posedge clk)
        !rst_n |=> !idle_flag);

endmodule

// File: tb/uart_idle_detect_tb.sv
`timescale 1ns/100ps
module uart_idle_detect_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_level = 1'b1;
    logic       bit_tick = 1'b0;
    logic       start_evt = 1'b0;
    logic       stop_end_evt = 1'b0;
    logic       char_stored = 1'b0;
    logic       break_set = 1'b0;
    logic [3:0] char_len = 4'd10;
    logic       idle_after_stop = 1'b0;
    logic       clear_w1c = 1'b0;
    logic       idle_flag;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    uart_idle_detect u_dut (
        .clk(clk), .rst_n(rst_n), .rx_level(rx_level), .bit_tick(bit_tick),
        .start_evt(start_evt), .stop_end_evt(stop_end_evt),
        .char_stored(char_stored), .break_set(break_set),
        .char_len(char_len), .idle_after_stop(idle_after_stop),
        .clear_w1c(clear_w1c), .idle_flag(idle_flag)
    );

    // Vector: {mode, char_len, data byte, expected idle ticks to flag}
    localparam int NVEC = 10;
    localparam logic [17:0] VEC [NVEC] = '{
        {1'b0, 4'd10, 8'hFF, 5'd1},   // R3 all ones
        {1'b0, 4'd10, 8'h00, 5'd9},   // R3 only stop bit counts
        {1'b0, 4'd13, 8'hF0, 5'd8},   // R3 four trailing ones
        {1'b0, 4'd11, 8'h7F, 5'd10},  // R3 last data bit low
        {1'b0, 4'd12, 8'hC3, 5'd9},   // R3 two trailing ones
        {1'b1, 4'd10, 8'hFF, 5'd10},  // R4
        {1'b1, 4'd12, 8'h00, 5'd12},  // R4
        {1'b1, 4'd13, 8'hFF, 5'd13},  // R4
        {1'b0, 4'd9,  8'hFF, 5'd1},   // R2 low clamp to 10
        {1'b1, 4'd15, 8'hA5, 5'd13}   // R2 high clamp to 13
    };

    task automatic check(input logic act, input logic exp, input string req);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: idle_flag=%0b expected %0b", req, act, exp);
        end
    endtask

    task automatic check_n(input int act, input int exp, input string req);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: ticks=%0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick(input logic lvl);
        @(negedge clk);
        rx_level = lvl;
        bit_tick = 1'b1;
        @(negedge clk);
        bit_tick = 1'b0;
    endtask

    task automatic clear_flag();
        @(negedge clk);
        clear_w1c = 1'b1;
        @(negedge clk);
        clear_w1c = 1'b0;
    endtask

    // Start event, start bit, 8 data bits LSB first, stop bit, then store.
    task automatic send_frame(input logic [7:0] data);
        @(negedge clk);
        start_evt = 1'b1;
        rx_level  = 1'b0;
        @(negedge clk);
        start_evt = 1'b0;
        tick(1'b0);
        for (int i = 0; i < 8; i++) tick(data[i]);
        tick(1'b1);
        @(negedge clk);
        stop_end_evt = 1'b1;
        char_stored  = 1'b1;
        @(negedge clk);
        stop_end_evt = 1'b0;
        char_stored  = 1'b0;
        @(negedge clk);
    endtask

    task automatic ticks_to_flag(output int n);
        n = 0;
        while (!idle_flag && n < 20) begin
            tick(1'b1);
            @(negedge clk);
            n++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: run did not finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        check(idle_flag, 1'b0, "R1 in reset");
        rst_n = 1'b1;
        @(negedge clk);
        check(idle_flag, 1'b0, "R1 after reset");

        // R1: activity without a stored character leaves it disarmed
        @(negedge clk);
        start_evt = 1'b1;
        @(negedge clk);
        start_evt = 1'b0;
        repeat (20) tick(1'b1);
        @(negedge clk);
        check(idle_flag, 1'b0, "R1 disarmed idle");

        // Table walk
        for (int v = 0; v < NVEC; v++) begin
            idle_after_stop = VEC[v][17];
            char_len        = VEC[v][16:13];
            send_frame(VEC[v][12:5]);
            ticks_to_flag(n);
            check_n(n, int'(VEC[v][4:0]), VEC[v][17] ? "R4/R2 vector" : "R3/R2 vector");
            clear_flag();
        end

        // R6: one-shot, long idle after clear gives no new flag
        repeat (30) tick(1'b1);
        @(negedge clk);
        check(idle_flag, 1'b0, "R6 one-shot");

        // R8: break re-arms; count already saturated
        @(negedge clk);
        break_set = 1'b1;
        @(negedge clk);
        break_set = 1'b0;
        @(negedge clk);
        check(idle_flag, 1'b1, "R8 break rearm");

        // R9: sticky across further idle ticks
        repeat (5) tick(1'b1);
        @(negedge clk);
        check(idle_flag, 1'b1, "R9 sticky");

        // R7: clear
        clear_flag();
        @(negedge clk);
        check(idle_flag, 1'b0, "R7 clear");

        // R5: low glitch during idle restarts the count
        idle_after_stop = 1'b1;
        char_len        = 4'd10;
        send_frame(8'h55);
        repeat (5) tick(1'b1);
        tick(1'b0);
        repeat (9) tick(1'b1);
        @(negedge clk);
        check(idle_flag, 1'b0, "R5 before threshold");
        tick(1'b1);
        @(negedge clk);
        check(idle_flag, 1'b1, "R5 at threshold");

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule